// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a 2048-byte memory shared by two agents that each have a full port of their own: the left port serves a host and the right port serves a local controller. Each port has an 11-bit address, a write-data byte, a registered read-data byte, a chip select, read and write strobes, and an interrupt output. Both ports run on one clock, and both can reach every location in the same cycle.

Two locations act as doorbells, one for each direction. When the left port writes address 7FFh, the right interrupt rises. When the right port writes address 7FEh, the left interrupt rises. An interrupt stays up until its own port reads the doorbell the other side wrote. Both locations also hold ordinary data, so the byte written with the doorbell is the message itself. A same-address write collision has a fixed winner, and a read always returns the contents from before the current cycle's writes.

The memory ports are plain random-access control pins rather than streams. A request is taken whenever its port's chip select is high, with no back-pressure, and read data follows one clock later.

Top module: `dpmb_top`

## Requirements
- R1: A port's read request (cs=1, rd=1) loads the byte at its address onto that port's rdata after the next rising edge. rdata holds its value on any cycle without a read request on that port.
- R2: Both ports operate in the same cycle with no interference. A write by either port (cs=1, wr=1) to any address is seen by later reads from either port.
- R3: When both ports write the same address in the same cycle, the left port's byte is stored.
- R4: A read of an address that is written in the same cycle, by either port, returns the byte stored before that cycle.
- R5: A left-port write to address 7FFh raises r_irq after that edge.
- R6: A right-port write to address 7FEh raises l_irq after that edge.
- R7: A right-port read of 7FFh clears r_irq, and a left-port read of 7FEh clears l_irq. If a raising write and a clearing read of the same interrupt fall in the same cycle, the interrupt stays high.
- R8: The interrupts change for no other access. This covers a port reading its own outgoing doorbell, a port writing the other side's doorbell address, and any access to other addresses.
- R9: A synchronous active-high reset clears both interrupts and both rdata registers to zero. Array contents are undefined after reset.
- R10: With cs=0, the rd and wr strobes of that port have no effect on the array, on rdata or on the interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_cs | input | 1 | Left port select |
| l_rd | input | 1 | Left read strobe |
| l_wr | input | 1 | Left write strobe |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write byte |
| l_rdata | output | 8 | Left read byte, registered |
| l_irq | output | 1 | Left interrupt: right-to-left doorbell pending |
| r_cs | input | 1 | Right port select |
| r_rd | input | 1 | Right read strobe |
| r_wr | input | 1 | Right write strobe |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write byte |
| r_rdata | output | 8 | Right read byte, registered |
| r_irq | output | 1 | Right interrupt: left-to-right doorbell pending |

## Verification
A doorbell flag in the wrong state appears on an irq pin in the very cycle after the access that should have set or cleared it. The bench compares both interrupts on every clock, so such an error is caught at once. A wrong collision winner or a wrong read-before-write choice stays hidden in the array until that address is read again, and then shows as a wrong rdata byte one cycle after the read. The bench therefore re-reads collided and doorbell addresses directly after writing them. In the random phase it also keeps a small hot set of addresses so that such reads happen within a few cycles.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  // Address a side writes to ring the opposite side.
  function automatic int unsigned ring_addr(side_e s, int unsigned aw);
    return (s == SIDE_L) ? ((1 << aw) - 1) : ((1 << aw) - 2);
  endfunction

  // Address a side reads to acknowledge its own interrupt.
  function automatic int unsigned ack_addr(side_e s, int unsigned aw);
    return ring_addr((s == SIDE_L) ? SIDE_R : SIDE_L, aw);
  endfunction

endpackage

// File: rtl/dpmb_port_dec.sv
module dpmb_port_dec #(
  parameter int unsigned AW      = 11,
  parameter int unsigned RING_AT = 0,
  parameter int unsigned ACK_AT  = 0
) (
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic          we,
  output logic          re,
  output logic          ring,
  output logic          ack
);
  localparam logic [AW-1:0] RING_A = RING_AT[AW-1:0];
  localparam logic [AW-1:0] ACK_A  = ACK_AT[AW-1:0];

  always_comb begin
    we   = cs & wr;
    re   = cs & rd;
    ring = we && (addr == RING_A);
    ack  = re && (addr == ACK_A);
  end
endmodule

// File: rtl/dpmb_doorbell.sv
module dpmb_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  // R5 and R6: a ring raises the flag, and it also wins over a same-cycle ack (R7)
  a_r5_ring_raises: assert property (@(posedge clk) disable iff (rst) set |=> irq);
  a_r7_ack_clears:  assert property (@(posedge clk) disable iff (rst) (clr && !set) |=> !irq);
  a_r8_quiet_holds: assert property (@(posedge clk) disable iff (rst) (!set && !clr) |=> $stable(irq));
endmodule

// File: rtl/dpmb_array.sv
module dpmb_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_l,
  input  logic          re_l,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] wdata_l,
  output logic [DW-1:0] rdata_l,
  input  logic          we_r,
  input  logic          re_r,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] wdata_r,
  output logic [DW-1:0] rdata_r
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];
  logic          r_blocked;
  logic          r_commit;

  always_comb begin
    r_blocked = we_l && (addr_l == addr_r);
    r_commit  = we_r && !r_blocked;
  end

  // Array writes: the right side yields on a same-address collision.
  always_ff @(posedge clk) begin
    if (r_commit) cells[addr_r] <= wdata_r;
    if (we_l)     cells[addr_l] <= wdata_l;
  end

  // Read registers sample the contents from before this edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_l <= '0;
      rdata_r <= '0;
    end else begin
      if (re_l) rdata_l <= cells[addr_l];
      if (re_r) rdata_r <= cells[addr_r];
    end
  end

  // R3: after a collision, an immediate left re-read with no writes returns the left byte
  a_r3_left_wins: assert property (@(posedge clk) disable iff (rst)
    ($past(we_l && we_r && (addr_l == addr_r)) && re_l && !we_l && !we_r
      && (addr_l == $past(addr_l)))
    |=> (rdata_l == $past(wdata_l, 2)));
endmodule

// File: rtl/dpmb_top.sv
module dpmb_top #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_cs,
  input  logic          l_rd,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq,
  input  logic          r_cs,
  input  logic          r_rd,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq
);
  import dpmb_pkg::*;

  localparam int unsigned NSIDE = 2;

  logic [NSIDE-1:0] cs_v, rd_v, wr_v, we_v, re_v, ring_v, ack_v, irq_v;
  logic [AW-1:0]    addr_v [NSIDE];

  always_comb begin
    cs_v = {r_cs, l_cs};
    rd_v = {r_rd, l_rd};
    wr_v = {r_wr, l_wr};
    addr_v[SIDE_L] = l_addr;
    addr_v[SIDE_R] = r_addr;
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    localparam side_e SD = side_e'(g);

    dpmb_port_dec #(
      .AW(AW), .RING_AT(ring_addr(SD, AW)), .ACK_AT(ack_addr(SD, AW))
    ) u_dec (
      .cs(cs_v[g]), .rd(rd_v[g]), .wr(wr_v[g]), .addr(addr_v[g]),
      .we(we_v[g]), .re(re_v[g]), .ring(ring_v[g]), .ack(ack_v[g])
    );

    // This side's flag is rung by the peer and acknowledged locally.
    dpmb_doorbell u_bell (
      .clk(clk), .rst(rst), .set(ring_v[NSIDE-1-g]), .clr(ack_v[g]), .irq(irq_v[g])
    );
  end

  dpmb_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst(rst),
    .we_l(we_v[SIDE_L]), .re_l(re_v[SIDE_L]), .addr_l(l_addr), .wdata_l(l_wdata), .rdata_l(l_rdata),
    .we_r(we_v[SIDE_R]), .re_r(re_v[SIDE_R]), .addr_r(r_addr), .wdata_r(r_wdata), .rdata_r(r_rdata)
  );

  assign l_irq = irq_v[SIDE_L];
  assign r_irq = irq_v[SIDE_R];

  // R1: read data moves only on a read request
  a_r1_l_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !(l_cs && l_rd) |=> $stable(l_rdata));
  a_r1_r_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !(r_cs && r_rd) |=> $stable(r_rdata));
  // R9: reset leaves both interrupts and both read registers at zero
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!l_irq && !r_irq && l_rdata == '0 && r_rdata == '0));
  // R10: a deselected right port cannot ring the left side
  a_r10_l_irq_no_ring: assert property (@(posedge clk) disable iff (rst)
    (!r_cs && !l_irq && !(l_cs && l_rd)) |=> !l_irq);
endmodule

// File: tb/sim_dpmb_top.sv
`timescale 1ns/1ps
module sim_dpmb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        l_cs = 0, l_rd = 0, l_wr = 0, r_cs = 0, r_rd = 0, r_wr = 0;
  logic [10:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0;
  logic [7:0]  l_rdata, r_rdata;
  logic        l_irq, r_irq;

  dpmb_top u0 (
    .clk(clk), .rst(rst),
    .l_cs(l_cs), .l_rd(l_rd), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_irq(l_irq),
    .r_cs(r_cs), .r_rd(r_rd), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_irq(r_irq)
  );

  // Behavioural reference model
  logic [7:0] m_mem [2048];
  bit         m_kn  [2048];
  logic [7:0] e_l_rd = 0, e_r_rd = 0;
  bit         e_l_kn = 1, e_r_kn = 1;
  bit         e_l_irq = 0, e_r_irq = 0;
  int         vectors = 0, misses = 0;
  string      tag = "R9";

  task automatic check(string what, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s %s got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("l_irq", {7'd0, l_irq}, {7'd0, e_l_irq});
    check("r_irq", {7'd0, r_irq}, {7'd0, e_r_irq});
    if (e_l_kn) check("l_rdata", l_rdata, e_l_rd);
    if (e_r_kn) check("r_rdata", r_rdata, e_r_rd);
  endtask

  task automatic model_reset();
    e_l_rd = 0; e_r_rd = 0; e_l_kn = 1; e_r_kn = 1; e_l_irq = 0; e_r_irq = 0;
    for (int i = 0; i < 2048; i++) m_kn[i] = 0;
  endtask

  // Drive one cycle from a falling edge, update the model, compare after the rising edge.
  task automatic step(input bit lc, lr, lw, input logic [10:0] la, input logic [7:0] ld,
                      input bit rc, rr, rw, input logic [10:0] ra, input logic [7:0] rdv);
    bit set_l, set_r, clr_l, clr_r;
    l_cs = lc; l_rd = lr; l_wr = lw; l_addr = la; l_wdata = ld;
    r_cs = rc; r_rd = rr; r_wr = rw; r_addr = ra; r_wdata = rdv;
    if (lc && lr) begin e_l_rd = m_mem[la]; e_l_kn = m_kn[la]; end
    if (rc && rr) begin e_r_rd = m_mem[ra]; e_r_kn = m_kn[ra]; end
    set_r = lc && lw && la == 11'h7FF;
    clr_r = rc && rr && ra == 11'h7FF;
    set_l = rc && rw && ra == 11'h7FE;
    clr_l = lc && lr && la == 11'h7FE;
    if (set_r) e_r_irq = 1; else if (clr_r) e_r_irq = 0;
    if (set_l) e_l_irq = 1; else if (clr_l) e_l_irq = 0;
    if (rc && rw) begin m_mem[ra] = rdv; m_kn[ra] = 1; end
    if (lc && lw) begin m_mem[la] = ld;  m_kn[la] = 1; end
    @(posedge clk); #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic idle();
    step(0,0,0,0,0, 0,0,0,0,0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    misses++;
    $display("FAIL watchdog expired got running expected finished");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    tag = "R9"; compare_all();
    @(negedge clk); rst = 0;

    // R1 / R2: basic traffic on both ports
    tag = "R2";
    step(1,0,1,11'h005,8'hAA, 1,0,1,11'h100,8'h55);
    tag = "R1";
    step(1,1,0,11'h100,0, 1,1,0,11'h005,0);
    idle(); idle();
    step(1,1,0,11'h005,0, 0,0,0,0,0);

    // R3: both ports write one address
    tag = "R3";
    step(1,0,1,11'h009,8'h11, 1,0,1,11'h009,8'h22);
    step(1,1,0,11'h009,0, 1,1,0,11'h009,0);

    // R4: read during a write returns the old byte
    tag = "R4";
    step(1,1,1,11'h009,8'h33, 1,1,0,11'h009,0);
    step(0,0,0,0,0, 1,1,1,11'h009,8'h44);
    step(1,1,0,11'h009,0, 0,0,0,0,0);

    // R5 / R7: left-to-right doorbell
    tag = "R5";
    step(1,0,1,11'h7FF,8'hC1, 0,0,0,0,0);
    tag = "R8";
    step(1,1,0,11'h7FF,0, 0,0,0,0,0);
    step(0,0,0,0,0, 1,0,1,11'h7FF,8'h99);
    tag = "R7";
    step(0,0,0,0,0, 1,1,0,11'h7FF,0);
    step(1,0,1,11'h7FF,8'hC2, 0,0,0,0,0);
    step(1,0,1,11'h7FF,8'hC3, 1,1,0,11'h7FF,0);
    step(0,0,0,0,0, 1,1,0,11'h7FF,0);

    // R6 / R7: right-to-left doorbell
    tag = "R6";
    step(0,0,0,0,0, 1,0,1,11'h7FE,8'h5A);
    tag = "R8";
    step(1,0,1,11'h7FE,8'h01, 1,1,0,11'h7FE,0);
    tag = "R7";
    step(1,1,0,11'h7FE,0, 0,0,0,0,0);

    // R10: deselected strobes do nothing
    tag = "R10";
    step(0,1,1,11'h009,8'hEE, 0,1,1,11'h7FE,8'hEE);
    step(0,1,1,11'h7FF,8'hEE, 0,1,0,11'h7FF,0);
    step(1,1,0,11'h009,0, 1,1,0,11'h7FE,0);

    // R2: random mixed traffic on a hot address set
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic [10:0] la, ra;
      int unsigned pick;
      pick = $urandom % 8;
      la = (pick < 2) ? 11'h7FF : (pick < 4) ? 11'h7FE : (pick < 6) ? 11'(pick) : 11'($urandom);
      pick = $urandom % 8;
      ra = (pick < 2) ? 11'h7FF : (pick < 4) ? 11'h7FE : (pick < 6) ? 11'(pick) : 11'($urandom);
      step(bit'($urandom), bit'($urandom), bit'($urandom), la, 8'($urandom),
           bit'($urandom), bit'($urandom), bit'($urandom), ra, 8'($urandom));
    end

    // R9: reset with both interrupts pending
    tag = "R9";
    step(1,0,1,11'h7FF,8'h77, 1,0,1,11'h7FE,8'h66);
    rst = 1;
    model_reset();
    @(posedge clk); #1;
    compare_all();
    @(negedge clk); rst = 0;
    idle();

    summary();
  end
endmodule